// File: doc/BRIEF.md
# Priority Load Shedding Supervisor

This block is the supervisory decision stage of a small islanded power system. It receives two unsigned power figures, one for total generation and one for total demand, together with a periodic evaluate strobe. On each strobe it compares the two figures and takes at most one switching step. The steps are: dropping a non-critical load, bringing one back, or opening or closing the backup diesel generator contactor. The critical load is outside its control and stays supplied at all times.

When demand is too high, loads are dropped in a fixed priority order: the lower-priority feeder goes first, then the higher-priority one. The generator is brought in only when both feeders are already off and the shortfall remains. When there is a surplus, the generator is released first. The loads then come back in the reverse of the order they were dropped, one per strobe. A hysteresis margin keeps the block from toggling when the two figures are nearly equal. A status byte holds the commands, the current state and the last action, so that a network layer can send it as a control message.

Top module: `shed_supervisor`

## Requirements
- R1: After a synchronous reset, both non-critical load commands are 1 (on), the generator command is 0 (off), and the status byte is 0x03.
- R2: A deficit is load power minus generated power strictly greater than HYST (default 16). A deficit with both loads on switches load 2 off and leaves load 1 on.
- R3: A deficit with load 2 off and load 1 on switches load 1 off.
- R4: A surplus is generated power minus load power strictly greater than HYST. A surplus with both loads off and the generator off restores load 1 only. A later surplus with only load 2 off restores load 2.
- R5: The generator command rises only on a deficit strobe while both loads are already off.
- R6: Outputs and status change only on the clock edge that samples eval_i high, and at most one of the three commands changes per strobe.
- R7: A strobe where the two powers differ by HYST or less, in either direction, changes no command.
- R8: A surplus strobe while the generator is on switches the generator off and restores no load in that step.
- R9: The status byte is updated on every strobe. Its layout is [7:5] action (0 hold, 1 shed, 2 restore, 3 generator start, 4 generator stop), [4:3] state (0 all on, 1 load 2 off, 2 both off, 3 generator on), [2] generator, [1] load 1, [0] load 2.
- R10: A deficit while the generator is already on, and a surplus while all loads are on, are held with action code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluate strobe, one decision per high cycle |
| gen_pwr_i | input | PWR_W | Generated power, unsigned |
| load_pwr_i | input | PWR_W | Load power, unsigned |
| ncl1_on_o | output | 1 | Non-critical load 1 command (1 = on) |
| ncl2_on_o | output | 1 | Non-critical load 2 command (1 = on) |
| dg_on_o | output | 1 | Generator contactor command (1 = closed) |
| status_o | output | 8 | Packed status byte |

## Verification
The two functions that compete in one cycle are releasing the generator and restoring load 1. Both are valid answers to a surplus once every load is off and the generator is running. The bench first drives the supervisor into the generator-on state with a run of deficit strobes. It then applies a single surplus strobe and requires that only the generator command falls, that load 1 stays off, and that the status byte reports action 4. A second surplus strobe must then restore load 1 with action 2.

// File: rtl/shed_pkg.sv
package shed_pkg;
  localparam int ST_W  = 2;
  localparam int ACT_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_ALL_ON   = 2'd0,
    ST_L2_OFF   = 2'd1,
    ST_BOTH_OFF = 2'd2,
    ST_GEN_ON   = 2'd3
  } shed_state_e;

  typedef enum logic [ACT_W-1:0] {
    ACT_HOLD    = 3'd0,
    ACT_SHED    = 3'd1,
    ACT_RESTORE = 3'd2,
    ACT_GEN_UP  = 3'd3,
    ACT_GEN_DN  = 3'd4
  } shed_act_e;
endpackage

// File: rtl/shed_margin_cmp.sv
module shed_margin_cmp #(
  parameter int PWR_W = 16,
  parameter int HYST  = 16
) (
  input  logic [PWR_W-1:0] gen_pwr,
  input  logic [PWR_W-1:0] load_pwr,
  output logic             deficit,
  output logic             surplus
);
  localparam int EXT_W = PWR_W + 2;
  localparam logic [EXT_W-1:0] HYST_EXT = EXT_W'(HYST);

  logic [EXT_W-1:0] gen_ext, load_ext;

  always_comb begin
    gen_ext  = {2'b00, gen_pwr};
    load_ext = {2'b00, load_pwr};
    // strict margin: a difference equal to HYST is treated as balanced
    deficit  = load_ext > (gen_ext + HYST_EXT);
    surplus  = gen_ext > (load_ext + HYST_EXT);
  end

  always_comb begin
    a_r7_not_both: assert (!(deficit && surplus));
  end
endmodule

// File: rtl/shed_step_fsm.sv
module shed_step_fsm
  import shed_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        eval,
  input  logic        deficit,
  input  logic        surplus,
  output shed_state_e state,
  output shed_act_e   action,
  output logic        ncl1_on,
  output logic        ncl2_on,
  output logic        dg_on
);
  shed_state_e nxt_state;
  shed_act_e   nxt_action;

  always_comb begin
    nxt_state  = state;
    nxt_action = ACT_HOLD;
    unique case (state)
      ST_ALL_ON: begin
        if (deficit) begin
          nxt_state  = ST_L2_OFF;
          nxt_action = ACT_SHED;
        end
      end
      ST_L2_OFF: begin
        if (deficit) begin
          nxt_state  = ST_BOTH_OFF;
          nxt_action = ACT_SHED;
        end else if (surplus) begin
          nxt_state  = ST_ALL_ON;
          nxt_action = ACT_RESTORE;
        end
      end
      ST_BOTH_OFF: begin
        if (deficit) begin
          nxt_state  = ST_GEN_ON;
          nxt_action = ACT_GEN_UP;
        end else if (surplus) begin
          nxt_state  = ST_L2_OFF;
          nxt_action = ACT_RESTORE;
        end
      end
      ST_GEN_ON: begin
        // releasing the generator outranks any restore
        if (surplus) begin
          nxt_state  = ST_BOTH_OFF;
          nxt_action = ACT_GEN_DN;
        end
      end
      default: begin
        nxt_state  = ST_ALL_ON;
        nxt_action = ACT_HOLD;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_ALL_ON;
      action  <= ACT_HOLD;
      ncl1_on <= 1'b1;
      ncl2_on <= 1'b1;
      dg_on   <= 1'b0;
    end else if (eval) begin
      state   <= nxt_state;
      action  <= nxt_action;
      ncl1_on <= (nxt_state == ST_ALL_ON) || (nxt_state == ST_L2_OFF);
      ncl2_on <= (nxt_state == ST_ALL_ON);
      dg_on   <= (nxt_state == ST_GEN_ON);
    end
  end

  a_r3_l1_after_l2: assert property (@(posedge clk) disable iff (rst)
    $fell(ncl1_on) |-> $past(!ncl2_on));
  a_r4_l2_after_l1: assert property (@(posedge clk) disable iff (rst)
    $rose(ncl2_on) |-> $past(ncl1_on));
  a_r5_gen_start: assert property (@(posedge clk) disable iff (rst)
    $rose(dg_on) |-> $past(eval && deficit && !ncl1_on && !ncl2_on));
  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones({ncl1_on, ncl2_on, dg_on} ^ $past({ncl1_on, ncl2_on, dg_on})) <= 1);
  a_r8_gen_release_first: assert property (@(posedge clk) disable iff (rst)
    dg_on |=> !ncl1_on);
endmodule

// File: rtl/shed_status_pack.sv
module shed_status_pack
  import shed_pkg::*;
#(
  parameter int STAT_W = ACT_W + ST_W + 3
) (
  input  shed_act_e   action,
  input  shed_state_e state,
  input  logic        dg_on,
  input  logic        ncl1_on,
  input  logic        ncl2_on,
  output logic [STAT_W-1:0] status
);
  always_comb begin
    status = {action, state, dg_on, ncl1_on, ncl2_on};
  end
endmodule

// File: rtl/shed_supervisor.sv
module shed_supervisor
  import shed_pkg::*;
#(
  parameter int PWR_W = 16,
  parameter int HYST  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eval_i,
  input  logic [PWR_W-1:0] gen_pwr_i,
  input  logic [PWR_W-1:0] load_pwr_i,
  output logic             ncl1_on_o,
  output logic             ncl2_on_o,
  output logic             dg_on_o,
  output logic [7:0]       status_o
);
  localparam int STAT_W = ACT_W + ST_W + 3;

  logic        deficit, surplus;
  shed_state_e state;
  shed_act_e   action;
  logic [STAT_W-1:0] status_w;

  shed_margin_cmp #(.PWR_W(PWR_W), .HYST(HYST)) u_cmp (
    .gen_pwr  (gen_pwr_i),
    .load_pwr (load_pwr_i),
    .deficit  (deficit),
    .surplus  (surplus)
  );

  shed_step_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .eval    (eval_i),
    .deficit (deficit),
    .surplus (surplus),
    .state   (state),
    .action  (action),
    .ncl1_on (ncl1_on_o),
    .ncl2_on (ncl2_on_o),
    .dg_on   (dg_on_o)
  );

  shed_status_pack #(.STAT_W(STAT_W)) u_pack (
    .action  (action),
    .state   (state),
    .dg_on   (dg_on_o),
    .ncl1_on (ncl1_on_o),
    .ncl2_on (ncl2_on_o),
    .status  (status_w)
  );

  assign status_o = status_w;

  a_r6_quiet_without_eval: assert property (@(posedge clk) disable iff (rst)
    !eval_i |=> $stable(status_o));
  a_r7_balanced_holds: assert property (@(posedge clk) disable iff (rst)
    (eval_i && !deficit && !surplus) |=> $stable({ncl1_on_o, ncl2_on_o, dg_on_o}));
  a_r9_hold_code: assert property (@(posedge clk) disable iff (rst)
    (eval_i && !deficit && !surplus) |=> (status_o[7:5] == 3'd0));
endmodule

// File: tb/shed_supervisor_tb.sv
module shed_supervisor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eval_i = 1'b0;
  logic [15:0] gen_pwr_i = '0;
  logic [15:0] load_pwr_i = '0;
  logic        ncl1_on_o, ncl2_on_o, dg_on_o;
  logic [7:0]  status_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  shed_supervisor u_dut (
    .clk(clk), .rst(rst), .eval_i(eval_i),
    .gen_pwr_i(gen_pwr_i), .load_pwr_i(load_pwr_i),
    .ncl1_on_o(ncl1_on_o), .ncl2_on_o(ncl2_on_o),
    .dg_on_o(dg_on_o), .status_o(status_o)
  );

  function automatic logic [7:0] mk_stat(int act, int st, bit g, bit l1, bit l2);
    return {3'(act), 2'(st), g, l1, l2};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req, bit l1, bit l2, bit g, logic [7:0] st);
    check(req, {29'd0, ncl1_on_o, ncl2_on_o, dg_on_o}, {29'd0, l1, l2, g});
    check(req, {24'd0, status_o}, {24'd0, st});
  endtask

  // drives one strobe; returns at the falling edge after the sampling edge
  task automatic strobe(int g, int l);
    @(negedge clk);
    gen_pwr_i  = 16'(g);
    load_pwr_i = 16'(l);
    eval_i     = 1'b1;
    @(negedge clk);
    eval_i     = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R1 reset", 1, 1, 0, 8'h03);
  endtask

  task automatic t_margin();
    strobe(100, 116);   // deficit of exactly HYST
    check_all("R7 deficit at margin", 1, 1, 0, mk_stat(0, 0, 0, 1, 1));
    strobe(116, 100);   // surplus of exactly HYST
    check_all("R7 surplus at margin", 1, 1, 0, mk_stat(0, 0, 0, 1, 1));
    strobe(500, 100);   // surplus with all loads on
    check_all("R10 surplus all on", 1, 1, 0, mk_stat(0, 0, 0, 1, 1));
  endtask

  task automatic t_shed();
    strobe(100, 117);
    check_all("R2 first shed drops load 2", 1, 0, 0, mk_stat(1, 1, 0, 1, 0));
    strobe(100, 110);
    check_all("R7 balanced after shed", 1, 0, 0, mk_stat(0, 1, 0, 1, 0));
    strobe(0, 900);
    check_all("R3 second shed drops load 1", 0, 0, 0, mk_stat(1, 2, 0, 0, 0));
  endtask

  task automatic t_gen();
    strobe(10, 400);
    check_all("R5 generator starts", 0, 0, 1, mk_stat(3, 3, 1, 0, 0));
    strobe(10, 400);
    check_all("R10 deficit with generator on", 0, 0, 1, mk_stat(0, 3, 1, 0, 0));
  endtask

  task automatic t_quiet();
    @(negedge clk);
    gen_pwr_i  = 16'd9000;
    load_pwr_i = 16'd1;
    repeat (6) @(negedge clk);
    check_all("R6 no strobe no change", 0, 0, 1, mk_stat(0, 3, 1, 0, 0));
  endtask

  task automatic t_restore();
    strobe(400, 100);
    check_all("R8 generator released first", 0, 0, 0, mk_stat(4, 2, 0, 0, 0));
    strobe(400, 100);
    check_all("R4 load 1 restored first", 1, 0, 0, mk_stat(2, 1, 0, 1, 0));
    strobe(400, 100);
    check_all("R4 load 2 restored later", 1, 1, 0, mk_stat(2, 0, 0, 1, 1));
    strobe(400, 100);
    check_all("R9 hold code after restore", 1, 1, 0, mk_stat(0, 0, 0, 1, 1));
  endtask

  task automatic t_gen_guard();
    strobe(0, 300);
    check("R5 no generator with load 1 on", {31'd0, dg_on_o}, 32'd0);
    do_reset();
    check_all("R1 reset from shed state", 1, 1, 0, 8'h03);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_margin();
    t_shed();
    t_gen();
    t_quiet();
    t_restore();
    t_gen_guard();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule